// File: doc/BRIEF.md
# Reset Cause Capture Register

This block remembers which reset sources have fired since software last looked. Five external sources (power-on, external pin, brownout, watchdog, program/debug interface) arrive as one-cycle pulses. A sixth source is the software reset, which the block raises itself. Each source owns a sticky flag in an 8-bit status register. Software reads the flags and clears each one by writing a one to its bit.

A control register holds a software-reset request bit. That bit is guarded by an unlock window. Writing the signature 0xD8 to the lock register opens the window for four cycles. One control write inside the window is accepted, and then the window closes. An accepted request produces a one-cycle pulse on the software-reset output. The same pulse is fed back as the software reset event: it sets that source's flag and clears the request bit. There is no data stream here, so every pin is a plain control or status pin.

Top module: `reset_cause_capture`

## Requirements
- R1: After `rst_n` is released, the status register (offset 0) reads 0x00, the control register (offset 1) reads 0x00 and `sw_reset_o` is low.
- R2: A one-cycle pulse on a source sets its flag at the next clock edge, and the flag stays set across idle cycles. The flag bits are: power-on bit 0, external bit 1, brownout bit 2, watchdog bit 3, program/debug bit 4, software bit 5.
- R3: A bus write to offset 0 clears every flag whose data bit is one. Flags whose data bit is zero are left unchanged. Status bits 7:6 always read zero.
- R4: A power-on pulse sets bit 0 and clears bits 5:1 at the same edge. Bits set by other events in that same cycle stay set. The power-on flag is cleared only by a write-one to bit 0.
- R5: When several sources pulse in the same cycle, all of their flags are set.
- R6: If a write-one clear of a flag and a new event for that flag land in the same cycle, the flag stays set. Other bits in the same write are still cleared.
- R7: A write to the control register while the window is closed is ignored. The control bit stays 0 and no `sw_reset_o` pulse follows.
- R8: Writing 0xD8 to offset 2 opens the window. A control write in any of the next four cycles is accepted. A control write in the fifth cycle or later is ignored. Writing any other value to offset 2 does not open the window.
- R9: One accepted control write closes the window. A second control write right after it is ignored, even if the first write had data 0.
- R10: An accepted write with bit 0 set makes the control register read 0x01 and drives `sw_reset_o` high for exactly the next cycle. At the edge after that, the control register reads 0x00 and status bit 5 is set.
- R11: If any external reset source pulses in the same cycle as an accepted control write, the control bit stays 0 and no pulse is produced.
- R12: Control bits 7:1 read zero whatever was written, and offset 2 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous logic reset |
| evt_por | input | 1 | Power-on reset pulse |
| evt_ext | input | 1 | External pin reset pulse |
| evt_bod | input | 1 | Brownout reset pulse |
| evt_wdt | input | 1 | Watchdog reset pulse |
| evt_dbg | input | 1 | Program/debug interface reset pulse |
| bus_addr | input | 2 | Register offset: 0 status, 1 control, 2 lock |
| bus_we | input | 1 | Write enable, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sw_reset_o | output | 1 | One-cycle software reset request |

## Verification
The bound checker watches several rules on every cycle:
- a source pulse always sets its flag;
- power-on wipes every flag except those raised in the same cycle;
- an event beats a simultaneous clear;
- the control bit never rises without a qualifying write inside the window;
- each software pulse lasts one cycle and leaves the software flag set.

Only the bench's scenarios can show the rest. These are the exact window length (cycle four accepted, cycle five refused), closing after one write, a wrong signature, a control write discarded when a reset fires alongside it, and the readback of reserved bits after chosen writes.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 2;
  localparam int NUM_SRC    = 6;
  localparam int WIN_CYCLES = 4;
  localparam logic [DATA_W-1:0] UNLOCK_SIG = 8'hD8;

  // flag bit positions inside the status register
  localparam int IDX_POR = 0;
  localparam int IDX_EXT = 1;
  localparam int IDX_BOD = 2;
  localparam int IDX_WDT = 3;
  localparam int IDX_DBG = 4;
  localparam int IDX_SW  = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFS_STATUS = 2'd0,
    OFS_CTRL   = 2'd1,
    OFS_LOCK   = 2'd2
  } reg_ofs_e;
endpackage

// File: rtl/rcc_unlock_window.sv
module rcc_unlock_window #(
  parameter int DW  = 8,
  parameter int WIN = 4,
  parameter logic [DW-1:0] SIG = 8'hD8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_wr,
  input  logic [DW-1:0] wdata,
  input  logic          ctrl_wr,
  output logic          win_open,
  output logic          accept
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] cnt_q;

  assign win_open = (cnt_q != '0);
  assign accept   = ctrl_wr && win_open;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (lock_wr && wdata == SIG) cnt_q <= CW'(WIN);
    else if (accept)                 cnt_q <= '0;
    else if (win_open)               cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/rcc_flag_bank.sv
module rcc_flag_bank #(
  parameter int N       = 6,
  parameter int POR_IDX = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] nxt;

  // power-on wipes the other flags; a same-cycle event always wins
  for (genvar i = 0; i < N; i++) begin : g_flag
    if (i == POR_IDX) begin : g_por
      assign nxt[i] = (flags[i] & ~clr[i]) | evt[i];
    end else begin : g_other
      assign nxt[i] = (flags[i] & ~clr[i] & ~evt[POR_IDX]) | evt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end
endmodule

// File: rtl/rcc_swrst_ctrl.sv
module rcc_swrst_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic wbit,
  input  logic any_reset,
  output logic ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         ctrl_q <= 1'b0;
    else if (any_reset) ctrl_q <= 1'b0;
    else if (accept)    ctrl_q <= wbit;
  end
endmodule

// File: rtl/reset_cause_capture.sv
module reset_cause_capture
  import rcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_por,
  input  logic              evt_ext,
  input  logic              evt_bod,
  input  logic              evt_wdt,
  input  logic              evt_dbg,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sw_reset_o
);
  logic [NUM_SRC-1:0] events;
  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] flags_q;
  logic               ctrl_q;
  logic               win_open;
  logic               accept;
  logic               lock_wr;
  logic               ctrl_wr;
  logic               hw_reset;

  assign sw_reset_o = ctrl_q;
  assign hw_reset   = evt_por | evt_ext | evt_bod | evt_wdt | evt_dbg;

  always_comb begin
    events          = '0;
    events[IDX_POR] = evt_por;
    events[IDX_EXT] = evt_ext;
    events[IDX_BOD] = evt_bod;
    events[IDX_WDT] = evt_wdt;
    events[IDX_DBG] = evt_dbg;
    events[IDX_SW]  = ctrl_q;
  end

  assign lock_wr  = bus_we && (bus_addr == OFS_LOCK);
  assign ctrl_wr  = bus_we && (bus_addr == OFS_CTRL);
  assign clr_mask = (bus_we && bus_addr == OFS_STATUS) ? bus_wdata[NUM_SRC-1:0] : '0;

  rcc_unlock_window #(
    .DW (DATA_W),
    .WIN(WIN_CYCLES),
    .SIG(UNLOCK_SIG)
  ) win_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_wr (lock_wr),
    .wdata   (bus_wdata),
    .ctrl_wr (ctrl_wr),
    .win_open(win_open),
    .accept  (accept)
  );

  rcc_flag_bank #(
    .N      (NUM_SRC),
    .POR_IDX(IDX_POR)
  ) flags_i (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (events),
    .clr  (clr_mask),
    .flags(flags_q)
  );

  rcc_swrst_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .wbit     (bus_wdata[0]),
    .any_reset(hw_reset | ctrl_q),
    .ctrl_q   (ctrl_q)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_STATUS: bus_rdata[NUM_SRC-1:0] = flags_q;
      OFS_CTRL:   bus_rdata[0]           = ctrl_q;
      default:    bus_rdata              = '0;
    endcase
  end
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_por,
  input logic       evt_ext,
  input logic       evt_bod,
  input logic       evt_wdt,
  input logic       evt_dbg,
  input logic [1:0] bus_addr,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       sw_reset_o,
  input logic [5:0] flags,
  input logic       ctrl_q,
  input logic       win_open
);
  logic [4:0] others;
  assign others = {sw_reset_o, evt_dbg, evt_wdt, evt_bod, evt_ext};

  AST_EXT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ext |=> flags[1]); // R2

  AST_SIMUL_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wdt && evt_bod) |=> (flags[3] && flags[2])); // R5

  AST_POR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    evt_por |=> (flags[0] && ((flags[5:1] & ~$past(others)) == 5'd0))); // R4

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_bod && bus_we && bus_addr == 2'd0 && bus_wdata[2]) |=> flags[2]); // R6

  AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[7:6] == 2'b00)); // R3

  AST_CTRL_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q) |-> $past(win_open && bus_we && bus_addr == 2'd1 && bus_wdata[0]
                            && !(evt_por || evt_ext || evt_bod || evt_wdt || evt_dbg))); // R7

  AST_SWRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_o |=> (!sw_reset_o && flags[5])); // R10
endmodule

bind reset_cause_capture rcc_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_por   (evt_por),
  .evt_ext   (evt_ext),
  .evt_bod   (evt_bod),
  .evt_wdt   (evt_wdt),
  .evt_dbg   (evt_dbg),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .sw_reset_o(sw_reset_o),
  .flags     (flags_q),
  .ctrl_q    (ctrl_q),
  .win_open  (win_open)
);

// File: tb/reset_cause_capture_tb_top.sv
module reset_cause_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_por = 1'b0, evt_ext = 1'b0, evt_bod = 1'b0, evt_wdt = 1'b0, evt_dbg = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       sw_reset_o;

  typedef struct {
    bit         on_swo;
    logic [7:0] exp;
    string      req;
  } sb_item_t;

  sb_item_t sb_q[$];
  sb_item_t cur;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_cause_capture dut_i (
    .clk(clk), .rst_n(rst_n),
    .evt_por(evt_por), .evt_ext(evt_ext), .evt_bod(evt_bod),
    .evt_wdt(evt_wdt), .evt_dbg(evt_dbg),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sw_reset_o(sw_reset_o)
  );

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      logic [7:0] act;
      cur = sb_q.pop_front();
      act = cur.on_swo ? {7'd0, sw_reset_o} : bus_rdata;
      n_cmp++;
      if (act !== cur.exp) begin
        n_bad++;
        $display("FAIL %s actual=0x%02h expected=0x%02h", cur.req, act, cur.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0; bus_wdata = 8'd0;
  endtask

  // mask order {dbg, wdt, bod, ext, por}
  task automatic pulse(input logic [4:0] m);
    {evt_dbg, evt_wdt, evt_bod, evt_ext, evt_por} = m;
    tick();
    {evt_dbg, evt_wdt, evt_bod, evt_ext, evt_por} = 5'd0;
  endtask

  // expectations for the current cycle; the monitor compares them before the next edge
  task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string r);
    sb_item_t it;
    bus_addr = a;
    it.on_swo = 1'b0; it.exp = e; it.req = r;
    sb_q.push_back(it);
  endtask

  task automatic exp_sw(input logic e, input string r);
    sb_item_t it;
    it.on_swo = 1'b1; it.exp = {7'd0, e}; it.req = r;
    sb_q.push_back(it);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    exp_rd(2'd0, 8'h00, "R1 status"); tick();
    exp_rd(2'd1, 8'h00, "R1 ctrl"); exp_sw(1'b0, "R1 swo"); tick();

    // R2 individual sources, sticky
    pulse(5'b00010); exp_rd(2'd0, 8'h02, "R2 ext"); tick();
    pulse(5'b00100); exp_rd(2'd0, 8'h06, "R2 bod"); tick();
    pulse(5'b01000); exp_rd(2'd0, 8'h0E, "R2 wdt"); tick();
    pulse(5'b10000); exp_rd(2'd0, 8'h1E, "R2 dbg"); tick();
    repeat (5) tick();
    exp_rd(2'd0, 8'h1E, "R2 sticky"); tick();

    // R3 write-one-to-clear
    wr(2'd0, 8'h04); exp_rd(2'd0, 8'h1A, "R3 clear bit2"); tick();
    wr(2'd0, 8'h00); exp_rd(2'd0, 8'h1A, "R3 zero write"); tick();
    wr(2'd0, 8'hC0); exp_rd(2'd0, 8'h1A, "R3 reserved bits"); tick();

    // R4 power-on behaviour
    pulse(5'b00001); exp_rd(2'd0, 8'h01, "R4 por wipes"); tick();
    pulse(5'b00010); exp_rd(2'd0, 8'h03, "R4 por kept"); tick();
    wr(2'd0, 8'h02); exp_rd(2'd0, 8'h01, "R4 por survives"); tick();
    wr(2'd0, 8'h01); exp_rd(2'd0, 8'h00, "R4 por w1c"); tick();

    // R5 simultaneous sources
    pulse(5'b01110); exp_rd(2'd0, 8'h0E, "R5 three at once"); tick();
    pulse(5'b10001); exp_rd(2'd0, 8'h11, "R5 por with dbg"); tick();

    // R6 event beats clear
    wr(2'd0, 8'h3F);
    pulse(5'b00100);
    bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h06; evt_ext = 1'b1;
    tick();
    bus_we = 1'b0; bus_wdata = 8'd0; evt_ext = 1'b0;
    exp_rd(2'd0, 8'h02, "R6 event wins"); tick();

    // R7 ctrl write without window
    wr(2'd1, 8'h01);
    exp_rd(2'd1, 8'h00, "R7 ctrl locked"); exp_sw(1'b0, "R7 no pulse"); tick();
    exp_sw(1'b0, "R7 no pulse later"); exp_rd(2'd0, 8'h02, "R7 flags"); tick();

    // R8 and R10 accepted in the fourth cycle of the window
    wr(2'd2, 8'hD8);
    repeat (3) tick();
    wr(2'd1, 8'h01);
    exp_rd(2'd1, 8'h01, "R10 ctrl set"); exp_sw(1'b1, "R8 accept cycle 4"); tick();
    exp_rd(2'd1, 8'h00, "R10 ctrl self clears"); exp_sw(1'b0, "R10 one cycle"); tick();
    exp_rd(2'd0, 8'h22, "R10 sw flag"); tick();

    // R8 fifth cycle refused
    wr(2'd2, 8'hD8);
    repeat (4) tick();
    wr(2'd1, 8'h01);
    exp_sw(1'b0, "R8 cycle 5 refused"); exp_rd(2'd1, 8'h00, "R8 ctrl 0"); tick();
    exp_rd(2'd0, 8'h22, "R8 flags unchanged"); tick();

    // R8 wrong signature
    wr(2'd2, 8'h55);
    wr(2'd1, 8'h01);
    exp_sw(1'b0, "R8 bad signature"); tick();

    // R9 one write closes window
    wr(2'd2, 8'hD8);
    wr(2'd1, 8'h00);
    exp_sw(1'b0, "R9 zero write"); tick();
    wr(2'd1, 8'h01);
    exp_sw(1'b0, "R9 second write refused"); exp_rd(2'd1, 8'h00, "R9 ctrl 0"); tick();

    // R11 reset in same cycle as accepted write
    wr(2'd2, 8'hD8);
    bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h01; evt_wdt = 1'b1;
    tick();
    bus_we = 1'b0; bus_wdata = 8'd0; evt_wdt = 1'b0;
    exp_rd(2'd1, 8'h00, "R11 ctrl discarded"); exp_sw(1'b0, "R11 no pulse"); tick();
    exp_rd(2'd0, 8'h2A, "R11 wdt flag"); tick();

    // R12 reserved control bits, lock readback
    wr(2'd2, 8'hD8);
    exp_rd(2'd2, 8'h00, "R12 lock reads 0"); tick();
    wr(2'd1, 8'hFE);
    exp_rd(2'd1, 8'h00, "R12 ctrl reserved"); exp_sw(1'b0, "R12 no pulse"); tick();

    tick();
    done = 1'b1;
    finish_run();
  end
endmodule